// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block decides whether the processor is diverted into an interrupt service routine. It watches two request levels. Level one is the OR of a group of device request lines, and level two is the OR of a second group. The processor pulses `fetch_start` at the boundary between instructions, and the request levels are judged only at that moment. Level one wins over level two. Each level also needs its enable flag. Level two further needs the level-one enable, so it is taken only when both flags are set.

When an interrupt is taken, the controller stalls the processor with `busy` and works through its own data-memory port. It pushes the current instruction pointer, then pushes the status word. Next it clears the enable flags that belong to the taken level. It then reads the vector word for that level from a fixed data address and hands the result to the processor as the new instruction pointer. The two vector words are ordinary memory, so software may rewrite them.

When the processor decodes the return-from-interrupt instruction (code 870000), it pulses `rti_go`. The controller then pops the status word and the instruction pointer, and it restores the two enable flags.

Top module: `intc_two_level`

## Requirements
- R1: After reset, IF1 and IF2 are 0, `sp` is 0x0800, and `busy`, `mem_req` and `ip_load` are low.
- R2: At a `fetch_start` cycle, level one is taken when any level-one source is high and IF1 is 1. This holds whatever the level-two state is, so level one has priority.
- R3: Level two is taken only when a level-two source is high, no level-one request is taken, and IF1 and IF2 are both 1. A level whose enable condition fails is not taken, and `busy` stays low.
- R4: Requests are judged only in a `fetch_start` cycle while the controller is idle. A held request with no `fetch_start` causes no entry. A `fetch_start` that arrives while `busy` is high is ignored.
- R5: The cycle after the decision, the controller writes the instruction pointer to address `sp`-1. The cycle after that, it writes the status word to address `sp`-2. `sp` ends 2 below its starting value.
- R6: The status word has N in bit 0, Z in bit 1, IF1 in bit 2 and IF2 in bit 3, with every other bit 0. The IF bits are the flag values in the decision cycle.
- R7: Taking level one clears both IF1 and IF2. Taking level two clears only IF2. The cleared flags are visible 3 cycles after the decision.
- R8: 3 cycles after the decision, the controller reads address 0x0FFF for level one or 0x0FFE for level two. One cycle later it pulses `ip_load`, and `ip_new` carries the word read, whatever value software stored there.
- R9: After an `rti_go` pulse, the controller reads `sp` in the next cycle and `sp`+1 in the cycle after. In that second cycle, `nz_load` pulses and `nz_new` carries bits 1:0 of the popped status word (bit 0 N, bit 1 Z). In the third cycle, IF1 and IF2 equal bits 2 and 3 of the popped status word, `ip_load` pulses with the popped instruction pointer, and `sp` is back at its starting value plus 2.
- R10: `flag_we` loads `flag_wdata` into the flags in the next cycle (bit 0 IF1, bit 1 IF2) while the controller is idle. While `busy` is high, it is ignored.
- R11: Requests are level-sensitive. Any single source of a group raises its level. A request still held after the service routine returns is taken again at the next `fetch_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq1_src | input | N_SRC1 | Level-one device request lines |
| irq2_src | input | N_SRC2 | Level-two device request lines |
| fetch_start | input | 1 | Pulse at the start of an instruction fetch |
| rti_go | input | 1 | Pulse when return-from-interrupt is decoded |
| cur_ip | input | 16 | Instruction pointer to save on entry |
| cur_n | input | 1 | Negative flag to save on entry |
| cur_z | input | 1 | Zero flag to save on entry |
| flag_we | input | 1 | Software write of the enable flags |
| flag_wdata | input | 2 | New flags: bit 0 IF1, bit 1 IF2 |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| busy | output | 1 | Sequence in progress; processor must stall |
| mem_req | output | 1 | Data-memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 16 | Write data |
| ip_load | output | 1 | Load `ip_new` into the instruction pointer |
| ip_new | output | 16 | New instruction pointer |
| nz_load | output | 1 | Restore N and Z from `nz_new` |
| nz_new | output | 2 | Restored flags: bit 0 N, bit 1 Z |
| if1 | output | 1 | Level-one enable flag |
| if2 | output | 1 | Level-two enable flag |
| sp | output | 16 | Stack pointer |

## Verification
Counting from the `fetch_start` cycle, entry results fall due on a fixed schedule:

| Cycle after decision | Result due |
|---|---|
| 1 | Instruction-pointer push |
| 2 | Status push |
| 3 | Vector read and cleared flags |
| 4 | `ip_load` |

On return, the two pops come in cycles 1 and 2 after `rti_go`, with `nz_load` in cycle 2. The flag restore and `ip_load` come in cycle 3.

The bench drives inputs at the falling edge and samples outputs at the next falling edge. Each check therefore sits at an exact cycle offset from its stimulus. A missing or extra register stage shifts a result out of its slot and makes the check fail.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_IP, ST_PUSH_ST, ST_VEC,
    ST_ENTER_LD, ST_POP_ST, ST_POP_IP, ST_EXIT_LD
  } seq_state_e;

  typedef enum logic [1:0] {LVL_NONE = 2'd0, LVL_ONE = 2'd1, LVL_TWO = 2'd2} lvl_e;

  // status word: bit0 N, bit1 Z, bit2 IF1, bit3 IF2
  function automatic logic [WORD_W-1:0] pack_status(input logic n, input logic z,
                                                    input logic f1, input logic f2);
    return {{(WORD_W-4){1'b0}}, f2, f1, z, n};
  endfunction

  function automatic lvl_e pick_level(input logic r1, input logic r2,
                                      input logic f1, input logic f2);
    if (r1 && f1) return LVL_ONE;
    if (r2 && f1 && f2) return LVL_TWO;
    return LVL_NONE;
  endfunction

  // mask bit0 clears IF1, bit1 clears IF2
  function automatic logic [1:0] clear_mask(input lvl_e l);
    case (l)
      LVL_ONE: return 2'b11;
      LVL_TWO: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int N_SRC1 = 4,
  parameter int N_SRC2 = 4
) (
  input  logic [N_SRC1-1:0] src1,
  input  logic [N_SRC2-1:0] src2,
  input  logic              if1,
  input  logic              if2,
  output logic              req1_any,
  output logic              req2_any,
  output lvl_e              level
);
  assign req1_any = |src1;
  assign req2_any = |src2;
  assign level    = pick_level(req1_any, req2_any, if1, if2);
endmodule

// File: rtl/intc_flags.sv
module intc_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_we,
  input  logic [1:0] sw_val,
  input  logic [1:0] clr_mask,
  input  logic       rest_we,
  input  logic [1:0] rest_val,
  output logic       if1,
  output logic       if2
);
  logic [1:0] flag_q;  // bit0 IF1, bit1 IF2

  always_ff @(posedge clk) begin
    if (!rst_n)           flag_q <= 2'b00;
    else if (rest_we)     flag_q <= rest_val;
    else if (|clr_mask)   flag_q <= flag_q & ~clr_mask;
    else if (sw_we)       flag_q <= sw_val;
  end

  assign if1 = flag_q[0];
  assign if2 = flag_q[1];
endmodule

// File: rtl/intc_seq.sv
module intc_seq
  import intc_pkg::*;
#(
  parameter logic [WORD_W-1:0] SP_INIT   = 16'h0800,
  parameter logic [WORD_W-1:0] VEC1_ADDR = 16'h0FFF,
  parameter logic [WORD_W-1:0] VEC2_ADDR = 16'h0FFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_start,
  input  logic              rti_go,
  input  lvl_e              level,
  input  logic [WORD_W-1:0] ip_in,
  input  logic              n_in,
  input  logic              z_in,
  input  logic              if1,
  input  logic              if2,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              ip_load,
  output logic [WORD_W-1:0] ip_new,
  output logic              nz_load,
  output logic [1:0]        nz_new,
  output logic [1:0]        clr_mask,
  output logic              rest_we,
  output logic [1:0]        rest_val,
  output logic [WORD_W-1:0] sp,
  output logic              enter_evt,
  output lvl_e              enter_lvl
);
  seq_state_e        st_q, st_d;
  logic [WORD_W-1:0] sp_q, sp_d, ip_sv_q, stat_sv_q;
  lvl_e              lvl_q;

  assign enter_evt = (st_q == ST_IDLE) && !rti_go && fetch_start && (level != LVL_NONE);
  assign enter_lvl = enter_evt ? level : LVL_NONE;
  assign busy      = (st_q != ST_IDLE);
  assign sp        = sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      sp_q      <= SP_INIT;
      ip_sv_q   <= '0;
      stat_sv_q <= '0;
      lvl_q     <= LVL_NONE;
    end else begin
      st_q <= st_d;
      sp_q <= sp_d;
      if (enter_evt) begin
        ip_sv_q   <= ip_in;
        stat_sv_q <= pack_status(n_in, z_in, if1, if2);
        lvl_q     <= level;
      end
    end
  end

  always_comb begin
    st_d      = st_q;
    sp_d      = sp_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    ip_load   = 1'b0;
    ip_new    = '0;
    nz_load   = 1'b0;
    nz_new    = 2'b00;
    clr_mask  = 2'b00;
    rest_we   = 1'b0;
    rest_val  = 2'b00;
    case (st_q)
      ST_IDLE: begin
        if (rti_go)         st_d = ST_POP_ST;
        else if (enter_evt) st_d = ST_PUSH_IP;
      end
      ST_PUSH_IP: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_q - 1'b1;
        mem_wdata = ip_sv_q;
        sp_d      = sp_q - 1'b1;
        st_d      = ST_PUSH_ST;
      end
      ST_PUSH_ST: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_q - 1'b1;
        mem_wdata = stat_sv_q;
        sp_d      = sp_q - 1'b1;
        clr_mask  = clear_mask(lvl_q);
        st_d      = ST_VEC;
      end
      ST_VEC: begin
        mem_req  = 1'b1;
        mem_addr = (lvl_q == LVL_ONE) ? VEC1_ADDR : VEC2_ADDR;
        st_d     = ST_ENTER_LD;
      end
      ST_ENTER_LD: begin
        ip_load = 1'b1;
        ip_new  = mem_rdata;
        st_d    = ST_IDLE;
      end
      ST_POP_ST: begin
        mem_req  = 1'b1;
        mem_addr = sp_q;
        sp_d     = sp_q + 1'b1;
        st_d     = ST_POP_IP;
      end
      ST_POP_IP: begin
        mem_req  = 1'b1;
        mem_addr = sp_q;
        sp_d     = sp_q + 1'b1;
        rest_we  = 1'b1;
        rest_val = mem_rdata[3:2];
        nz_load  = 1'b1;
        nz_new   = mem_rdata[1:0];
        st_d     = ST_EXIT_LD;
      end
      ST_EXIT_LD: begin
        ip_load = 1'b1;
        ip_new  = mem_rdata;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/intc_two_level.sv
module intc_two_level
  import intc_pkg::*;
#(
  parameter int                N_SRC1    = 4,
  parameter int                N_SRC2    = 4,
  parameter logic [WORD_W-1:0] SP_INIT   = 16'h0800,
  parameter logic [WORD_W-1:0] VEC1_ADDR = 16'h0FFF,
  parameter logic [WORD_W-1:0] VEC2_ADDR = 16'h0FFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC1-1:0] irq1_src,
  input  logic [N_SRC2-1:0] irq2_src,
  input  logic              fetch_start,
  input  logic              rti_go,
  input  logic [WORD_W-1:0] cur_ip,
  input  logic              cur_n,
  input  logic              cur_z,
  input  logic              flag_we,
  input  logic [1:0]        flag_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              ip_load,
  output logic [WORD_W-1:0] ip_new,
  output logic              nz_load,
  output logic [1:0]        nz_new,
  output logic              if1,
  output logic              if2,
  output logic [WORD_W-1:0] sp
);
  logic       req1_any, req2_any, enter_evt, rest_we;
  logic [1:0] clr_mask, rest_val;
  lvl_e       level, enter_lvl;
  logic       take1_evt, take2_evt;

  assign take1_evt = enter_evt && (enter_lvl == LVL_ONE);
  assign take2_evt = enter_evt && (enter_lvl == LVL_TWO);

  intc_arbiter #(.N_SRC1(N_SRC1), .N_SRC2(N_SRC2)) u_arb (
    .src1(irq1_src), .src2(irq2_src), .if1(if1), .if2(if2),
    .req1_any(req1_any), .req2_any(req2_any), .level(level)
  );

  intc_flags u_flags (
    .clk(clk), .rst_n(rst_n), .sw_we(flag_we && !busy), .sw_val(flag_wdata),
    .clr_mask(clr_mask), .rest_we(rest_we), .rest_val(rest_val),
    .if1(if1), .if2(if2)
  );

  intc_seq #(.SP_INIT(SP_INIT), .VEC1_ADDR(VEC1_ADDR), .VEC2_ADDR(VEC2_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_n), .fetch_start(fetch_start), .rti_go(rti_go),
    .level(level), .ip_in(cur_ip), .n_in(cur_n), .z_in(cur_z),
    .if1(if1), .if2(if2), .mem_rdata(mem_rdata),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .ip_load(ip_load), .ip_new(ip_new),
    .nz_load(nz_load), .nz_new(nz_new), .clr_mask(clr_mask),
    .rest_we(rest_we), .rest_val(rest_val), .sp(sp),
    .enter_evt(enter_evt), .enter_lvl(enter_lvl)
  );
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter logic [15:0] VEC1_ADDR = 16'h0FFF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [15:0] sp,
  input logic        if1,
  input logic        if2,
  input logic        ip_load,
  input logic        req1_any,
  input logic        req2_any,
  input logic        take1_evt,
  input logic        take2_evt
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !ip_load));  // R4
  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> (sp == $past(sp) - 16'd1));  // R5
  AST_TAKE1_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    take1_evt |-> (if1 && req1_any));  // R2
  AST_TAKE2_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    take2_evt |-> (if1 && if2 && req2_any && !req1_any));  // R3
  AST_LVL1_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_load && $past(take1_evt, 4)) |-> (!if1 && !if2));  // R7
  AST_LVL1_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take1_evt, 3) |-> (mem_req && !mem_we && mem_addr == VEC1_ADDR));  // R8
endmodule

bind intc_two_level intc_checker #(.VEC1_ADDR(VEC1_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .sp(sp), .if1(if1), .if2(if2), .ip_load(ip_load),
  .req1_any(req1_any), .req2_any(req2_any),
  .take1_evt(take1_evt), .take2_evt(take2_evt)
);

// File: tb/test_intc_two_level.sv
module test_intc_two_level;
  localparam int CLK_P = 10;
  localparam int N1 = 4;
  localparam int N2 = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N1-1:0] irq1_src = '0;
  logic [N2-1:0] irq2_src = '0;
  logic fetch_start = 1'b0, rti_go = 1'b0, cur_n = 1'b0, cur_z = 1'b0, flag_we = 1'b0;
  logic [15:0] cur_ip = '0;
  logic [1:0]  flag_wdata = '0;
  logic [15:0] mem_rdata = '0;
  logic busy, mem_req, mem_we, ip_load, nz_load, if1, if2;
  logic [15:0] mem_addr, mem_wdata, ip_new, sp;
  logic [1:0]  nz_new;

  int n_checks = 0;
  int n_fails  = 0;
  logic [15:0] dmem [0:4095];

  always #(CLK_P/2) clk = ~clk;

  intc_two_level i_intc_two_level (
    .clk(clk), .rst_n(rst_n), .irq1_src(irq1_src), .irq2_src(irq2_src),
    .fetch_start(fetch_start), .rti_go(rti_go), .cur_ip(cur_ip), .cur_n(cur_n),
    .cur_z(cur_z), .flag_we(flag_we), .flag_wdata(flag_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .ip_load(ip_load), .ip_new(ip_new), .nz_load(nz_load),
    .nz_new(nz_new), .if1(if1), .if2(if2), .sp(sp)
  );

  // synchronous data memory model, read data one cycle after the request
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) dmem[mem_addr[11:0]] <= mem_wdata;
      else        mem_rdata <= dmem[mem_addr[11:0]];
    end
  end

  function automatic int exp_level(input bit any1, input bit any2, input bit f1, input bit f2);
    if (!f1) return 0;
    if (any1) return 1;
    return (any2 && f2) ? 2 : 0;
  endfunction

  function automatic logic [15:0] exp_status(input bit n, input bit z, input bit f1, input bit f2);
    return 16'(int'(n) + 2*int'(z) + 4*int'(f1) + 8*int'(f2));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_flags(input bit f1, input bit f2);
    flag_we = 1'b1; flag_wdata = {f2, f1};
    @(negedge clk);
    flag_we = 1'b0;
    chk({if2, if1} == {f2, f1}, "R10 flag write", {14'd0, if2, if1}, {14'd0, f2, f1});
  endtask

  task automatic run_fetch(input logic [N1-1:0] s1, input logic [N2-1:0] s2,
                           input logic [15:0] ipv, input bit n, input bit z, input bit poke,
                           output int lvl, output logic [15:0] st);
    logic [15:0] sp0, vaddr, vval;
    logic [1:0]  fexp;
    bit f1, f2;
    sp0 = sp; f1 = if1; f2 = if2;
    lvl = exp_level(s1 != 0, s2 != 0, f1, f2);
    st  = exp_status(n, z, f1, f2);
    irq1_src = s1; irq2_src = s2; cur_ip = ipv; cur_n = n; cur_z = z;
    fetch_start = 1'b1;
    @(negedge clk);
    fetch_start = 1'b0;
    if (lvl == 0) begin
      chk(!busy && !mem_req, "R3 R2 no entry without enable", {15'd0, busy}, 16'd0);
      return;
    end
    chk(mem_req && mem_we && mem_addr == sp0 - 16'd1 && mem_wdata == ipv,
        "R5 ip push", mem_wdata, ipv);
    if (poke) begin flag_we = 1'b1; flag_wdata = 2'b11; fetch_start = 1'b1; end
    @(negedge clk);
    flag_we = 1'b0; fetch_start = 1'b0;
    chk(mem_req && mem_we && mem_addr == sp0 - 16'd2 && mem_wdata == st,
        "R6 R5 status push", mem_wdata, st);
    @(negedge clk);
    vaddr = (lvl == 1) ? 16'h0FFF : 16'h0FFE;
    vval  = dmem[vaddr[11:0]];
    fexp  = (lvl == 1) ? 2'b00 : {1'b0, f1};
    chk(mem_req && !mem_we && mem_addr == vaddr, "R8 vector address", mem_addr, vaddr);
    chk({if2, if1} == fexp, "R7 flags cleared", {14'd0, if2, if1}, {14'd0, fexp});
    @(negedge clk);
    chk(ip_load && ip_new == vval, "R8 vector loaded", ip_new, vval);
    chk(sp == sp0 - 16'd2, "R5 sp after entry", sp, sp0 - 16'd2);
    if (poke) chk({if2, if1} == fexp, "R10 write during entry ignored", {14'd0, if2, if1}, {14'd0, fexp});
    @(negedge clk);
    chk(!busy, "R4 idle after entry", {15'd0, busy}, 16'd0);
  endtask

  task automatic run_rti(input logic [15:0] exp_ip, input logic [15:0] st, input bit poke);
    logic [15:0] sp0;
    sp0 = sp;
    rti_go = 1'b1;
    @(negedge clk);
    rti_go = 1'b0;
    chk(mem_req && !mem_we && mem_addr == sp0, "R9 status pop address", mem_addr, sp0);
    @(negedge clk);
    chk(mem_req && !mem_we && mem_addr == sp0 + 16'd1, "R9 ip pop address", mem_addr, sp0 + 16'd1);
    chk(nz_load && nz_new == st[1:0], "R9 N Z restore", {14'd0, nz_new}, {14'd0, st[1:0]});
    @(negedge clk);
    chk(ip_load && ip_new == exp_ip, "R9 ip restore", ip_new, exp_ip);
    chk({if2, if1} == st[3:2], "R9 flag restore", {14'd0, if2, if1}, {14'd0, st[3:2]});
    chk(sp == sp0 + 16'd2, "R9 sp after return", sp, sp0 + 16'd2);
    if (poke) fetch_start = 1'b1;
    @(negedge clk);
    fetch_start = 1'b0;
    chk(!busy, "R4 fetch during return ignored", {15'd0, busy}, 16'd0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    int lvl;
    logic [15:0] st;
    int seed;
    for (int i = 0; i < 4096; i++) dmem[i] = 16'h0000;
    dmem[12'hFFF] = 16'h0D00;
    dmem[12'hFFE] = 16'h0E00;
    seed = $urandom(32'h1DEA5);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!if1 && !if2, "R1 flags after reset", {14'd0, if2, if1}, 16'd0);
    chk(sp == 16'h0800, "R1 sp after reset", sp, 16'h0800);
    chk(!busy && !mem_req && !ip_load, "R1 quiet after reset", {13'd0, busy, mem_req, ip_load}, 16'd0);

    // R2: request with flags off is not taken
    run_fetch(4'b0001, 4'b0000, 16'h0123, 1'b0, 1'b0, 1'b0, lvl, st);
    // R4: held request, enabled, no fetch_start
    set_flags(1'b1, 1'b1);
    irq1_src = 4'b0100;
    repeat (5) @(negedge clk);
    chk(!busy && !mem_req, "R4 no entry without fetch_start", {15'd0, busy}, 16'd0);
    // R2 priority: both levels pending
    run_fetch(4'b0100, 4'b0010, 16'h0456, 1'b1, 1'b0, 1'b0, lvl, st);
    chk(lvl == 1, "R2 level one chosen", 16'(lvl), 16'd1);
    run_rti(16'h0456, st, 1'b1);
    // R3: IF2 set but IF1 clear blocks level two
    set_flags(1'b0, 1'b1);
    run_fetch(4'b0000, 4'b1000, 16'h0777, 1'b0, 1'b1, 1'b0, lvl, st);
    // R3 R7: level two taken, IF1 kept
    set_flags(1'b1, 1'b1);
    run_fetch(4'b0000, 4'b1000, 16'h0777, 1'b0, 1'b1, 1'b1, lvl, st);
    chk(lvl == 2, "R3 level two chosen", 16'(lvl), 16'd2);
    run_rti(16'h0777, st, 1'b0);
    // R11: still held, taken again
    run_fetch(4'b0000, 4'b1000, 16'h0778, 1'b1, 1'b1, 1'b0, lvl, st);
    chk(lvl == 2, "R11 pending request retaken", 16'(lvl), 16'd2);
    run_rti(16'h0778, st, 1'b0);
    // R8: user-changed vector word
    dmem[12'hFFF] = 16'h1234;
    run_fetch(4'b1000, 4'b0000, 16'h0999, 1'b0, 1'b0, 1'b0, lvl, st);
    run_rti(16'h0999, st, 1'b0);

    // constrained random mix
    for (int k = 0; k < 60; k++) begin
      logic [N1-1:0] s1;
      logic [N2-1:0] s2;
      logic [15:0] ipv;
      s1 = ($urandom % 3 == 0) ? N1'(1 << ($urandom % N1)) : '0;
      s2 = ($urandom % 2 == 0) ? N2'(1 << ($urandom % N2)) : '0;
      ipv = 16'($urandom % 4096);
      if (k % 7 == 0) dmem[12'hFFE] = 16'($urandom);
      set_flags(1'($urandom), 1'($urandom));
      run_fetch(s1, s2, ipv, 1'($urandom), 1'($urandom), 1'b0, lvl, st);
      if (lvl != 0) run_rti(ipv, st, 1'b0);
    end
    irq1_src = '0; irq2_src = '0;
    @(negedge clk);
    chk(sp == 16'h0800, "R5 R9 stack balanced", sp, 16'h0800);

    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule